// File: doc/BRIEF.md
# TDM Daisy-Chain Receive Stage

This block is one receive stage of a time-division-multiplexed serial link. It holds a 64-bit shift register clocked by the serial bit clock. On every rising edge it takes one bit from its serial input into the least significant position, and its most significant bit leaves through a cascade output. Several identical stages can be wired output to input, so the chain acts as one long shift register. The required bit clock then scales with the chain: the number of stages times 64 times the frame rate must not exceed the highest bit-clock frequency the stages support.

A frame-sync input is sampled on the same bit-clock edge as the data. On an edge where frame sync is high, the stage copies its 64 bits in parallel. The upper half becomes the left word and the lower half becomes the right word. Bits travel most-significant first, so in a chain of two stages sharing one frame sync, the stage nearer the processor, which is fed by the far stage's cascade output, holds the first 64 bits of each 128-bit frame. A small state machine drives the valid strobe. It has two states. ST_IDLE means no new words. ST_PRESENT means the words were refreshed on the previous edge. The transitions are: ST_IDLE to ST_PRESENT on frame sync, ST_PRESENT to ST_PRESENT on another frame sync, ST_PRESENT to ST_IDLE without one, and ST_IDLE to ST_IDLE without one. Synchronous reset forces ST_IDLE.

Top module: `tdm_chain_stage`

## Requirements
- R1: A synchronous active-high reset clears the shift register, both output words, the valid strobe and the cascade output to 0 on the next rising edge.
- R2: On each rising bit-clock edge out of reset, the register moves one place toward the MSB and the serial input enters bit 0.
- R3: The cascade output equals the register MSB. It therefore presents the serial input bit sampled 64 edges earlier, or 0 if fewer than 64 bits have entered since reset.
- R4: On an edge where frame sync is high, the words are loaded from the 64 most recent bits including the bit sampled on that edge. The left word is bits 63..32 (the older 32 bits) and the right word is bits 31..0.
- R5: The valid output is high for exactly the cycle after each edge that sampled frame sync high, and it stays high on consecutive cycles for back-to-back frame syncs.
- R6: When frame sync is low on an edge, both output words keep their values.
- R7: With two stages chained (near stage fed from far stage cascade) and a shared frame sync, the near stage captures the older 64 bits of the most recent 128, and its cascade output repeats the bit sampled 128 edges earlier.
- R8: A frame sync at any bit position, including in the middle of a frame, does not disturb shifting or the cascade output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bclk | input | 1 | Serial bit clock; all logic runs on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| fsync | input | 1 | Frame sync, sampled with the data |
| ser_in | input | 1 | Serial data input, MSB first |
| casc_out | output | 1 | Register MSB, to the next stage's serial input |
| left_word | output | 32 | Upper half of the captured frame |
| right_word | output | 32 | Lower half of the captured frame |
| word_valid | output | 1 | One-cycle strobe after each capture |

## Verification
The checker watches every cycle for the per-edge rules. These are the one-place shift with the new bit at position 0, the cascade bit following the previous bit 62, the capture matching the register, the words holding when no sync arrives, the valid strobe tracking the sampled frame sync, and the zero state after reset. Only the bench scenarios can show the rules that span many edges. These are the 64- and 128-edge delays through one and two stages, the MSB-first mapping of whole frames onto left and right words, and the fact that the near stage of a chain holds the older half of each 128-bit frame. The bench covers these with a walking-one sweep over every bit position, arithmetic frame patterns, mid-frame and back-to-back syncs, and a reset in the middle of traffic.

// File: rtl/tdm_chain_pkg.sv
package tdm_chain_pkg;

    // Valid-strobe controller states
    typedef enum logic {
        ST_IDLE    = 1'b0,
        ST_PRESENT = 1'b1
    } cap_state_e;

endpackage

// File: rtl/tdm_shift_core.sv
module tdm_shift_core #(
    parameter int FRAME_W = 64
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               ser_in,
    output logic [FRAME_W-1:0] frame_d,
    output logic [FRAME_W-1:0] frame_q,
    output logic               msb_out
);

    // Next value: every bit takes its lower neighbour, bit 0 takes the input
    assign frame_d[0] = ser_in;

    genvar gi;
    generate
        for (gi = 1; gi < FRAME_W; gi++) begin : g_shift
            assign frame_d[gi] = frame_q[gi-1];
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            frame_q <= '0;
        end else begin
            frame_q <= frame_d;
        end
    end

    assign msb_out = frame_q[FRAME_W-1];

endmodule

// File: rtl/tdm_capture_fsm.sv
module tdm_capture_fsm
    import tdm_chain_pkg::*;
#(
    parameter int FRAME_W = 64,
    localparam int HALF_W = FRAME_W / 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               fsync,
    input  logic [FRAME_W-1:0] frame_d,
    output logic [HALF_W-1:0]  left_word,
    output logic [HALF_W-1:0]  right_word,
    output logic               word_valid
);

    cap_state_e state_q;
    cap_state_e state_d;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    state_d = fsync ? ST_PRESENT : ST_IDLE;
            ST_PRESENT: state_d = fsync ? ST_PRESENT : ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Output process: parallel load of both channel words
    logic [HALF_W-1:0] slot_q [2];

    genvar ch;
    generate
        for (ch = 0; ch < 2; ch++) begin : g_slot
            // ch 0 = left (upper half), ch 1 = right (lower half)
            localparam int LO = (1 - ch) * HALF_W;
            always_ff @(posedge clk) begin
                if (rst) begin
                    slot_q[ch] <= '0;
                end else if (fsync) begin
                    slot_q[ch] <= frame_d[LO +: HALF_W];
                end
            end
        end
    endgenerate

    assign left_word  = slot_q[0];
    assign right_word = slot_q[1];
    assign word_valid = (state_q == ST_PRESENT);

endmodule

// File: rtl/tdm_chain_stage.sv
module tdm_chain_stage #(
    parameter int FRAME_W = 64,
    localparam int HALF_W = FRAME_W / 2
) (
    input  logic              bclk,
    input  logic              rst,
    input  logic              fsync,
    input  logic              ser_in,
    output logic              casc_out,
    output logic [HALF_W-1:0] left_word,
    output logic [HALF_W-1:0] right_word,
    output logic              word_valid
);

    logic [FRAME_W-1:0] frame_d;
    logic [FRAME_W-1:0] frame_q;

    tdm_shift_core #(
        .FRAME_W (FRAME_W)
    ) u_shift (
        .clk     (bclk),
        .rst     (rst),
        .ser_in  (ser_in),
        .frame_d (frame_d),
        .frame_q (frame_q),
        .msb_out (casc_out)
    );

    tdm_capture_fsm #(
        .FRAME_W (FRAME_W)
    ) u_capture (
        .clk        (bclk),
        .rst        (rst),
        .fsync      (fsync),
        .frame_d    (frame_d),
        .left_word  (left_word),
        .right_word (right_word),
        .word_valid (word_valid)
    );

endmodule

// File: rtl/tdm_chain_stage_checker.sv
module tdm_chain_stage_checker #(
    parameter int FRAME_W = 64,
    localparam int HALF_W = FRAME_W / 2
) (
    input logic               bclk,
    input logic               rst,
    input logic               fsync,
    input logic               ser_in,
    input logic               casc_out,
    input logic [HALF_W-1:0]  left_word,
    input logic [HALF_W-1:0]  right_word,
    input logic               word_valid,
    input logic [FRAME_W-1:0] frame_q
);

    assert_reset_clear_R1: assert property (@(posedge bclk) disable iff (rst)
        $past(rst) |-> (!word_valid && left_word == '0 && right_word == '0
                        && casc_out == 1'b0 && frame_q == '0));

    assert_shift_step_R2: assert property (@(posedge bclk) disable iff (rst)
        !$past(rst) |-> frame_q == {$past(frame_q[FRAME_W-2:0]), $past(ser_in)});

    assert_cascade_msb_R3: assert property (@(posedge bclk) disable iff (rst)
        !$past(rst) |-> casc_out == $past(frame_q[FRAME_W-2]));

    assert_capture_match_R4: assert property (@(posedge bclk) disable iff (rst)
        fsync |=> {left_word, right_word} == frame_q);

    assert_valid_follows_R5: assert property (@(posedge bclk) disable iff (rst)
        fsync |=> word_valid);

    assert_valid_quiet_R5: assert property (@(posedge bclk) disable iff (rst)
        !fsync |=> !word_valid);

    assert_words_hold_R6: assert property (@(posedge bclk) disable iff (rst)
        !fsync |=> ($stable(left_word) && $stable(right_word)));

endmodule

bind tdm_chain_stage tdm_chain_stage_checker #(
    .FRAME_W (FRAME_W)
) u_chk (
    .bclk       (bclk),
    .rst        (rst),
    .fsync      (fsync),
    .ser_in     (ser_in),
    .casc_out   (casc_out),
    .left_word  (left_word),
    .right_word (right_word),
    .word_valid (word_valid),
    .frame_q    (frame_q)
);

// File: tb/tdm_chain_stage_bench.sv
module tdm_chain_stage_bench;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG_CYCLES = 150000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        fsync = 1'b0;
    logic        sdi = 1'b0;

    logic        casc_a, casc_b;
    logic [31:0] left_a, right_a, left_b, right_b;
    logic        valid_a, valid_b;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    // Bench model: the last 128 serial bits, newest in bit 0
    logic [127:0] hist = '0;
    logic [31:0]  exp_la = '0, exp_ra = '0, exp_lb = '0, exp_rb = '0;
    logic         exp_valid = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    // Far stage: fed by the bench
    tdm_chain_stage u_tdm_chain_stage (
        .bclk       (clk),
        .rst        (rst),
        .fsync      (fsync),
        .ser_in     (sdi),
        .casc_out   (casc_a),
        .left_word  (left_a),
        .right_word (right_a),
        .word_valid (valid_a)
    );

    // Near stage: fed by the far stage cascade
    tdm_chain_stage u_tdm_chain_stage_near (
        .bclk       (clk),
        .rst        (rst),
        .fsync      (fsync),
        .ser_in     (casc_a),
        .casc_out   (casc_b),
        .left_word  (left_b),
        .right_word (right_b),
        .word_valid (valid_b)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One bit-clock edge with the given inputs, then every output checked
    task automatic step(input logic d, input logic f, input string shift_tag);
        @(negedge clk);
        rst   = 1'b0;
        sdi   = d;
        fsync = f;
        @(posedge clk);
        #1;
        hist = {hist[126:0], d};
        exp_valid = f;
        if (f) begin
            exp_la = hist[63:32];
            exp_ra = hist[31:0];
            exp_lb = hist[127:96];
            exp_rb = hist[95:64];
        end
        chk({shift_tag, " cascade far"}, {63'd0, casc_a}, {63'd0, hist[63]});
        chk("R7 cascade near", {63'd0, casc_b}, {63'd0, hist[127]});
        chk("R5 valid", {62'd0, valid_b, valid_a}, {62'd0, exp_valid, exp_valid});
        chk(f ? "R4 words far" : "R6 words far hold", {left_a, right_a}, {exp_la, exp_ra});
        chk(f ? "R7 words near" : "R6 words near hold", {left_b, right_b}, {exp_lb, exp_rb});
    endtask

    task automatic send_frame(input logic [63:0] val, input string shift_tag);
        for (int b = 63; b >= 0; b--) begin
            step(val[b], (b == 0), shift_tag);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst   = 1'b1;
        fsync = 1'b0;
        sdi   = 1'b1;
        @(posedge clk);
        #1;
        hist = '0;
        exp_la = '0; exp_ra = '0; exp_lb = '0; exp_rb = '0;
        exp_valid = 1'b0;
        chk("R1 reset far", {left_a, right_a}, 64'd0);
        chk("R1 reset near", {left_b, right_b}, 64'd0);
        chk("R1 reset flags", {60'd0, casc_a, casc_b, valid_a, valid_b}, 64'd0);
    endtask

    initial begin
        repeat (2) @(posedge clk);
        do_reset();

        // Walking one over every frame bit position
        for (int p = 0; p < 64; p++) begin
            send_frame(64'd1 << p, "R2 R3");
        end

        // Arithmetic frame patterns
        for (int i = 0; i < 24; i++) begin
            logic [63:0] v;
            v = (64'(i) + 64'd1) * 64'h9E37_79B9_7F4A_7C15;
            v = v ^ (64'(i) << 40);
            send_frame(v, "R2 R3");
        end

        // Frame sync at irregular positions, mid-frame
        for (int k = 0; k < 90; k++) begin
            step(((k * 7 + 3) % 5) < 2, (k % 13) == 6, "R8");
        end

        // Back-to-back frame syncs
        for (int k = 0; k < 4; k++) begin
            step(k[0], 1'b1, "R8");
        end
        step(1'b1, 1'b0, "R8");

        // Reset in the middle of traffic, then fresh frames
        for (int k = 0; k < 20; k++) begin
            step(k[1], 1'b0, "R3");
        end
        do_reset();
        send_frame(64'hFEDC_BA98_7654_3210, "R3");
        send_frame(64'h0F1E_2D3C_4B5A_6978, "R3");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * WATCHDOG_CYCLES);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule